// File: doc/BRIEF.md
# Priority Preemptive Task Scheduler

This block tracks which tasks are ready to run and decides each clock which one owns the processor. Every task carries a configured priority level, and a larger number means a more urgent task. The highest level with any ready task always wins. A task at a higher level that becomes ready displaces the running one on the same clock edge.

Tasks that share the winning level take turns. The turn passes to the next ready task in ascending index order, wrapping around. This happens either when the running task yields or when its time slice runs out. The time slice is a programmable number of tick pulses, and the count restarts whenever the running task changes or the turn is taken.

Ready and block events arrive as per-task pulse vectors. The outputs are the chosen task index, a flag that says whether any task is ready, and a one-cycle pulse that marks a change of task.

Top module: `task_sched`

## Requirements
- R1: A bit of `ready_set_i` marks that task ready and a bit of `block_i` clears it, both at the next rising edge. When a task has both bits high in the same cycle, the block wins. The selection made at that edge already reflects the change.
- R2: Whenever `cur_valid_o` is high, `cur_id_o` names a task that is ready. `cur_valid_o` is low exactly when no task is ready.
- R3: The priority of task t is `prio_i[t*PRIO_W +: PRIO_W]`, and a larger value is more urgent. At every edge the selected task is at the highest level among the ready tasks. A newly ready task at a strictly higher level takes over at that edge. A new task at an equal or lower level does not displace the running task.
- R4: A `yield_i` pulse passes the processor to the next ready task at the same level, searching upward from the running index and wrapping from the top index to 0.
- R5: A yield when no other task at the running task's level is ready leaves the running task selected, with no preempt pulse.
- R6: With `slice_len_i` = L > 0, the time-slice count restarts at every change of task and at every rotation. The L-th `tick_i` pulse after that restart rotates exactly like a yield. A yield on the same edge as a tick is a single rotation.
- R7: With `slice_len_i` = 0 loaded at the last restart, ticks never rotate.
- R8: A slice expiry when no other task at the running level is ready leaves the running task selected, with no preempt pulse.
- R9: `preempt_o` is high for exactly the cycle in which `cur_valid_o` is high and `cur_id_o` differs from the previous cycle's value, or the previous cycle had no valid task. It is low in every other cycle.
- R10: When the running task is blocked, the pick among the remaining top-level tasks starts at the index after the blocked one, circularly.
- R11: After reset no task is ready, and both `cur_valid_o` and `preempt_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_set_i | input | N_TASKS | Per-task pulse: task becomes ready |
| block_i | input | N_TASKS | Per-task pulse: task blocks (wins over set) |
| yield_i | input | 1 | Running task gives up its turn |
| tick_i | input | 1 | Time-slice tick |
| slice_len_i | input | SLICE_W | Ticks per slice, 0 disables slicing |
| prio_i | input | N_TASKS*PRIO_W | Packed per-task priority levels |
| cur_id_o | output | $clog2(N_TASKS) | Selected task index |
| cur_valid_o | output | 1 | At least one task is ready |
| preempt_o | output | 1 | One-cycle pulse on a change of task |

## Verification
The bench builds the block with eight tasks, three-bit priorities and a four-bit slice count. At that size the circular search visibly wraps from index 7 to index 0. The setup also places four levels in use at once, so arrivals from above, below and at the same level all occur within a short script. The short slice length lets a full expiry, an expiry with a lone task and a yield colliding with a tick all happen within a few cycles. The scoreboard predicts every cycle's index, valid flag and pulse from the requirements.

// File: rtl/sched_pkg.sv
package sched_pkg;
  // index after cur, wrapping at n
  function automatic int unsigned wrap_next(int unsigned cur, int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/sched_ready_map.sv
module sched_ready_map #(
  parameter int unsigned N_TASKS = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_TASKS-1:0] set_i,
  input  logic [N_TASKS-1:0] block_i,
  output logic [N_TASKS-1:0] ready_d_o,
  output logic [N_TASKS-1:0] ready_q_o
);
  logic [N_TASKS-1:0] ready_q;

  // block dominates set
  assign ready_d_o = (ready_q | set_i) & ~block_i;
  assign ready_q_o = ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= '0;
    else         ready_q <= ready_d_o;
  end
endmodule

// File: rtl/sched_top_level.sv
module sched_top_level #(
  parameter int unsigned N_TASKS = 32,
  parameter int unsigned PRIO_W  = 5
) (
  input  logic [N_TASKS-1:0]        ready_i,
  input  logic [N_TASKS*PRIO_W-1:0] prio_i,
  output logic [N_TASKS-1:0]        cand_o,
  output logic                      any_o
);
  localparam int unsigned N_LVL = 1 << PRIO_W;

  logic [N_LVL-1:0]  lvl_hit;
  logic [PRIO_W-1:0] top_lvl;

  for (genvar p = 0; p < N_LVL; p++) begin : g_lvl
    logic [N_TASKS-1:0] member;
    for (genvar t = 0; t < N_TASKS; t++) begin : g_task
      assign member[t] = ready_i[t] && (prio_i[t*PRIO_W +: PRIO_W] == PRIO_W'(p));
    end
    assign lvl_hit[p] = |member;
  end

  always_comb begin
    top_lvl = '0;
    for (int p = 0; p < N_LVL; p++) begin
      if (lvl_hit[p]) top_lvl = PRIO_W'(p);
    end
  end

  for (genvar t = 0; t < N_TASKS; t++) begin : g_cand
    assign cand_o[t] = ready_i[t] && (prio_i[t*PRIO_W +: PRIO_W] == top_lvl);
  end

  assign any_o = |ready_i;
endmodule

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
  parameter int unsigned N_TASKS = 32,
  localparam int unsigned IW = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
  input  logic [N_TASKS-1:0] mask_i,
  input  logic [IW-1:0]      start_i,
  output logic [IW-1:0]      idx_o,
  output logic               found_o
);
  // first set bit at or after start_i, circular
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < N_TASKS; i++) begin
      int j;
      j = int'(start_i) + i;
      if (j >= N_TASKS) j = j - N_TASKS;
      if (!found_o && mask_i[j]) begin
        found_o = 1'b1;
        idx_o   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/sched_slice_timer.sv
module sched_slice_timer #(
  parameter int unsigned SLICE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reload_i,
  input  logic               tick_i,
  input  logic               run_i,
  input  logic [SLICE_W-1:0] len_i,
  output logic               expire_o
);
  logic [SLICE_W-1:0] left_q;

  // a count of 0 never expires, so len 0 disables slicing
  assign expire_o = tick_i && run_i && (left_q == SLICE_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              left_q <= '0;
    else if (reload_i)                        left_q <= len_i;
    else if (tick_i && run_i && left_q != '0) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/task_sched.sv
module task_sched
  import sched_pkg::*;
#(
  parameter int unsigned N_TASKS = 32,
  parameter int unsigned PRIO_W  = 5,
  parameter int unsigned SLICE_W = 16,
  localparam int unsigned IW = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_TASKS-1:0]        ready_set_i,
  input  logic [N_TASKS-1:0]        block_i,
  input  logic                      yield_i,
  input  logic                      tick_i,
  input  logic [SLICE_W-1:0]        slice_len_i,
  input  logic [N_TASKS*PRIO_W-1:0] prio_i,
  output logic [IW-1:0]             cur_id_o,
  output logic                      cur_valid_o,
  output logic                      preempt_o
);
  logic [N_TASKS-1:0] ready_d, ready_q, cand;
  logic               any_rdy, found, slice_exp, rotate, do_switch, reload;
  logic [IW-1:0]      cur_q, start_idx, sel_idx;
  logic               valid_q, preempt_q;

  sched_ready_map #(.N_TASKS(N_TASKS)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (ready_set_i),
    .block_i   (block_i),
    .ready_d_o (ready_d),
    .ready_q_o (ready_q)
  );

  sched_top_level #(.N_TASKS(N_TASKS), .PRIO_W(PRIO_W)) u_lvl (
    .ready_i (ready_d),
    .prio_i  (prio_i),
    .cand_o  (cand),
    .any_o   (any_rdy)
  );

  // rotation starts after the running index; otherwise the running task wins if still a candidate
  assign rotate    = valid_q && (yield_i || slice_exp);
  assign start_idx = rotate ? IW'(wrap_next(int'(cur_q), N_TASKS)) : cur_q;

  sched_rr_pick #(.N_TASKS(N_TASKS)) u_pick (
    .mask_i  (cand),
    .start_i (start_idx),
    .idx_o   (sel_idx),
    .found_o (found)
  );

  assign do_switch = found && (!valid_q || sel_idx != cur_q);
  assign reload    = do_switch || (rotate && found);

  sched_slice_timer #(.SLICE_W(SLICE_W)) u_slice (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (reload),
    .tick_i   (tick_i),
    .run_i    (valid_q),
    .len_i    (slice_len_i),
    .expire_o (slice_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q     <= '0;
      valid_q   <= 1'b0;
      preempt_q <= 1'b0;
    end else begin
      valid_q   <= any_rdy;
      preempt_q <= do_switch;
      if (found) cur_q <= sel_idx;
    end
  end

  assign cur_id_o    = cur_q;
  assign cur_valid_o = valid_q;
  assign preempt_o   = preempt_q;

  logic unused_ready;
  assign unused_ready = ^ready_q;
endmodule

// File: rtl/task_sched_chk.sv
module task_sched_chk #(
  parameter int unsigned N_TASKS = 32,
  parameter int unsigned PRIO_W  = 5,
  localparam int unsigned IW = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [N_TASKS-1:0]        block_i,
  input logic [N_TASKS*PRIO_W-1:0] prio_i,
  input logic [N_TASKS-1:0]        ready_q,
  input logic [IW-1:0]             cur_id_o,
  input logic                      cur_valid_o,
  input logic                      preempt_o
);
  logic [N_TASKS*PRIO_W-1:0] prio_d;
  always_ff @(posedge clk_i) prio_d <= prio_i;

  p_sel_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_valid_o |-> ready_q[cur_id_o]);

  p_valid_any_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_valid_o == (|ready_q));

  p_pulse_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preempt_o |-> cur_valid_o);

  p_hold_id_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_valid_o && $past(cur_valid_o) && !preempt_o) |-> $stable(cur_id_o));

  for (genvar t = 0; t < N_TASKS; t++) begin : g_t
    p_top_prio_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cur_valid_o && ready_q[t]) |->
        prio_d[t*PRIO_W +: PRIO_W] <= prio_d[int'(cur_id_o)*PRIO_W +: PRIO_W]);

    p_block_wins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(block_i[t]) |-> !ready_q[t]);
  end
endmodule

bind task_sched task_sched_chk #(.N_TASKS(N_TASKS), .PRIO_W(PRIO_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .block_i     (block_i),
  .prio_i      (prio_i),
  .ready_q     (ready_q),
  .cur_id_o    (cur_id_o),
  .cur_valid_o (cur_valid_o),
  .preempt_o   (preempt_o)
);

// File: tb/task_sched_bench.sv
`timescale 1ns/1ps
module task_sched_bench;
  localparam int N  = 8;
  localparam int PW = 3;
  localparam int SW = 4;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [N-1:0]  set_v = '0, blk_v = '0;
  logic          yld = 0, tck = 0;
  logic [SW-1:0] slen = '0;
  logic [N*PW-1:0] prio = '0;
  logic [2:0]    id;
  logic          vld, pre;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // expected: {chk_id, valid, id[2:0], preempt}
  logic [5:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  task_sched #(.N_TASKS(N), .PRIO_W(PW), .SLICE_W(SW)) u_task_sched (
    .clk_i(clk), .rst_ni(rst_n), .ready_set_i(set_v), .block_i(blk_v),
    .yield_i(yld), .tick_i(tck), .slice_len_i(slen), .prio_i(prio),
    .cur_id_o(id), .cur_valid_o(vld), .preempt_o(pre)
  );

  task automatic step(input logic [N-1:0] s, input logic [N-1:0] b, input logic y,
                      input logic t, input logic ev, input logic [2:0] eid,
                      input logic ep, input logic cid, input string tag);
    @(negedge clk);
    set_v = s; blk_v = b; yld = y; tck = t;
    exp_q.push_back({cid, ev, eid, ep});
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(posedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [5:0] e;
      string tg;
      #1;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      n_cmp++;
      if (vld !== e[4] || pre !== e[0] || (e[5] && id !== e[3:1])) begin
        n_bad++;
        $display("FAIL %s: got valid=%0b id=%0d pre=%0b, expected valid=%0b id=%0d pre=%0b",
                 tg, vld, id, pre, e[4], e[3:1], e[0]);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // priorities: t0..t2=1, t3,t4=4, t5=6, t6=0, t7=1
    prio[0*PW +: PW] = 3'd1; prio[1*PW +: PW] = 3'd1; prio[2*PW +: PW] = 3'd1;
    prio[3*PW +: PW] = 3'd4; prio[4*PW +: PW] = 3'd4; prio[5*PW +: PW] = 3'd6;
    prio[6*PW +: PW] = 3'd0; prio[7*PW +: PW] = 3'd1;
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;
    if (vld !== 1'b0 || pre !== 1'b0) begin
      n_bad++;
      $display("FAIL R11: got valid=%0b pre=%0b, expected 0 0", vld, pre);
    end
    @(negedge clk); rst_n = 1;

    step(8'h01, 8'h00, 0, 0, 1, 3'd0, 1, 1, "R1 first ready");
    step(8'h00, 8'h00, 0, 0, 1, 3'd0, 0, 1, "R9 quiet cycle");
    step(8'h06, 8'h00, 0, 0, 1, 3'd0, 0, 1, "R3 equal arrival");
    step(8'h00, 8'h00, 1, 0, 1, 3'd1, 1, 1, "R4 yield 0->1");
    step(8'h00, 8'h00, 1, 0, 1, 3'd2, 1, 1, "R4 yield 1->2");
    step(8'h00, 8'h00, 1, 0, 1, 3'd0, 1, 1, "R4 yield wrap 2->0");
    step(8'h00, 8'h00, 0, 1, 1, 3'd0, 0, 1, "R7 tick with slicing off");
    step(8'h08, 8'h00, 0, 0, 1, 3'd3, 1, 1, "R3 higher preempts");
    step(8'h40, 8'h00, 0, 0, 1, 3'd3, 0, 1, "R3 lower ignored");
    step(8'h00, 8'h00, 1, 0, 1, 3'd3, 0, 1, "R5 yield alone");
    step(8'h20, 8'h00, 0, 0, 1, 3'd5, 1, 1, "R3 top level preempts");
    step(8'h00, 8'h20, 0, 0, 1, 3'd3, 1, 1, "R10 running blocked");
    step(8'h10, 8'h00, 0, 0, 1, 3'd3, 0, 1, "R3 equal joins level");
    slen = 4'd3;
    step(8'h00, 8'h00, 1, 0, 1, 3'd4, 1, 1, "R6 yield reloads slice");
    step(8'h00, 8'h00, 0, 1, 1, 3'd4, 0, 1, "R6 tick 1 of 3");
    step(8'h00, 8'h00, 0, 1, 1, 3'd4, 0, 1, "R6 tick 2 of 3");
    step(8'h00, 8'h00, 0, 1, 1, 3'd3, 1, 1, "R6 slice expiry rotates");
    step(8'h00, 8'h00, 0, 0, 1, 3'd3, 0, 1, "R6 hold after expiry");
    step(8'h00, 8'h00, 1, 1, 1, 3'd4, 1, 1, "R6 yield with tick");
    step(8'h00, 8'h10, 0, 0, 1, 3'd3, 1, 1, "R10 blocked, wrap pick");
    step(8'h00, 8'h00, 0, 1, 1, 3'd3, 0, 1, "R8 tick 1 alone");
    step(8'h00, 8'h00, 0, 1, 1, 3'd3, 0, 1, "R8 tick 2 alone");
    step(8'h00, 8'h00, 0, 1, 1, 3'd3, 0, 1, "R8 expiry alone");
    step(8'h00, 8'h08, 0, 0, 1, 3'd0, 1, 1, "R10 drop to lower level");
    step(8'h01, 8'h07, 0, 0, 1, 3'd6, 1, 1, "R1 block wins over set");
    step(8'h00, 8'h40, 0, 0, 0, 3'd0, 0, 0, "R2 none ready");
    step(8'h40, 8'h00, 0, 0, 1, 3'd6, 1, 1, "R9 resume after idle");
    step(8'h40, 8'h40, 0, 0, 0, 3'd0, 0, 0, "R1 set and block same cycle");
    step(8'h00, 8'h00, 0, 0, 0, 3'd0, 0, 0, "R2 stays idle");

    @(negedge clk);
    set_v = '0; blk_v = '0; yld = 0; tck = 0;
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule